// File: doc/BRIEF.md
# Nibble-Serial Byte ALU

This block is the arithmetic and logic datapath of a small 8-bit processor, built around a 4-bit core. A byte operation takes two consecutive clock cycles. The first pass works on the low nibble. The second pass works on the high nibble and receives the carry and parity produced by the first pass. Both nibble results are collected in a result latch.

Two operand latches are loaded from an internal byte bus. Any of the following can drive that bus:
- one of the two operand latches,
- the result latch,
- an input shifter fed from the external data input,
- a generator that produces a one-hot bit mask.

An instruction decoder outside this block drives every control input directly, cycle by cycle.

Flag-preparation outputs are taken from the registered pass results and from the result latch. They cover:
- carry, half carry and signed overflow,
- zero and sign,
- the two copy bits (result bits 5 and 3),
- the comparisons a decimal adjust needs.

Top module: `nib_alu`

## Requirements
- R1: After reset, both operand latches, the result latch and the carry, half-carry and overflow flags are 0. The zero flag `zf` reads 1.
- R2: `ext_dout` shows the internal bus while `ext_oe` is 1, and reads 0 while `ext_oe` is 0. The `bus_src` code selects what drives the bus:
  - 1: first operand latch
  - 2: second operand latch
  - 3: result latch
  - 4: shifter
  - 5: bit-mask generator
  - 0, 6, 7: the bus carries 0
- R3: The shifter output depends on `sh_right` and `sh_left`:
  - `sh_right` = 1: `{sh_in, ext_din[7:1]}`. Right takes priority over left.
  - `sh_left` = 1 (right low): `{ext_din[6:0], sh_in}`.
  - Neither: `ext_din` unchanged.
  - `sh_lsb` and `sh_msb` always mirror `ext_din[0]` and `ext_din[7]`.
- R4: The bit-mask generator drives a byte with only bit `bit_idx` set.
- R5: `op1_ld` controls the first operand latch at the clock edge:
  - 0: hold
  - 1: load the bus
  - 2: load `{4'h0, bus[3:0]}`
  - 3: clear
- R6: `op2_ld` controls the second operand latch at the clock edge:
  - 0: hold
  - 1: load the bus
  - 2: load the result latch
  - 3: clear
- R7: The two passes and the operand nibbles:
  - A cycle with `pass_lo` = 1 runs the core on `op1[3:0]` and writes the core result into `res[3:0]`.
  - Otherwise, a cycle with `pass_hi` = 1 runs the core on `op1[7:4]` and writes `res[7:4]`. The other nibble is left unchanged.
  - The second core operand is `op2[7:4]` when `op2_hi` = 1, and `op2[3:0]` otherwise.
- R8: `op_code` selects the core operation and its low-pass carry-in:
  - 0: add, carry-in 0
  - 1: add, carry-in `carry_in`
  - 2: subtract, carry-in 1
  - 3: subtract with borrow, carry-in `!carry_in`
  - 4: AND
  - 5: OR
  - 6: XOR
  - 7: pass the first operand nibble

  Codes 2 and 3, and `op2_neg` = 1, complement the second operand nibble. In a high pass, codes 0 to 3 take the stored half carry as carry-in.
- R9: The carry flags are registered at the pass that produces them:
  - `hf` is the carry out of the last low pass.
  - `cf` is the carry out of the last high pass. For subtraction, 1 means no borrow.
  - `vf` is the signed 4-bit overflow of the last high pass.
  - Codes 4 to 7 produce no carry and no overflow.
- R10: `par_out` is combinational. It equals `par_in` XOR the parity of the current core result nibble.
- R11: `sf`, `yf` and `xf` are result-latch bits 7, 5 and 3. `zf` is 1 exactly when the low pass and the high pass each last produced a zero nibble.
- R12: `lo_gt9` is `res[3:0]` > 9. `hi_gt9` is `res[7:4]` > 9. `hi_eq9` is `res[7:4]` == 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_din | input | 8 | External data into the shifter |
| ext_oe | input | 1 | Drive the internal bus onto `ext_dout` |
| ext_dout | output | 8 | External data out |
| bus_src | input | 3 | Internal bus source code |
| sh_right | input | 1 | Shift right |
| sh_left | input | 1 | Shift left |
| sh_in | input | 1 | Bit shifted in |
| sh_lsb | output | 1 | Incoming bit 0 |
| sh_msb | output | 1 | Incoming bit 7 |
| bit_idx | input | 3 | Bit-mask index |
| op1_ld | input | 2 | First operand latch load code |
| op2_ld | input | 2 | Second operand latch load code |
| op2_neg | input | 1 | Complement the second operand nibble |
| op2_hi | input | 1 | Use the high nibble of the second operand |
| pass_lo | input | 1 | Low-nibble pass |
| pass_hi | input | 1 | High-nibble pass |
| op_code | input | 3 | Core operation |
| carry_in | input | 1 | Carry for the carry and borrow variants |
| par_in | input | 1 | Parity of the previous nibble |
| par_out | output | 1 | Running parity |
| cf | output | 1 | Carry flag |
| hf | output | 1 | Half-carry flag |
| vf | output | 1 | Overflow flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign bit |
| yf | output | 1 | Result bit 5 |
| xf | output | 1 | Result bit 3 |
| lo_gt9 | output | 1 | Low result nibble above 9 |
| hi_gt9 | output | 1 | High result nibble above 9 |
| hi_eq9 | output | 1 | High result nibble equal to 9 |

## Verification
The bench builds the block with its default nibble width of 4, so operands are bytes and the core is 4 bits wide. At this width every one of the 16 core operand values and every carry-in combination can be reached through short two-pass sequences. Random operand pairs run through all eight operation codes with chained parity. These runs exercise the half-carry feed, signed overflow at the 4-bit boundary and the decimal-adjust comparisons near 9, alongside directed shifter, mask and latch-load cases.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  localparam logic [2:0] SRC_NONE = 3'd0;
  localparam logic [2:0] SRC_OP1  = 3'd1;
  localparam logic [2:0] SRC_OP2  = 3'd2;
  localparam logic [2:0] SRC_RES  = 3'd3;
  localparam logic [2:0] SRC_SHF  = 3'd4;
  localparam logic [2:0] SRC_BIT  = 3'd5;

  localparam logic [2:0] OPC_ADD  = 3'd0;
  localparam logic [2:0] OPC_ADC  = 3'd1;
  localparam logic [2:0] OPC_SUB  = 3'd2;
  localparam logic [2:0] OPC_SBC  = 3'd3;
  localparam logic [2:0] OPC_AND  = 3'd4;
  localparam logic [2:0] OPC_OR   = 3'd5;
  localparam logic [2:0] OPC_XOR  = 3'd6;
  localparam logic [2:0] OPC_PASS = 3'd7;

  function automatic logic is_arith(input logic [2:0] opc);
    return opc < OPC_AND;
  endfunction

  function automatic logic is_sub(input logic [2:0] opc);
    return (opc == OPC_SUB) || (opc == OPC_SBC);
  endfunction
endpackage

// File: rtl/nib_alu_shift.sv
module nib_alu_shift #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] din,
  input  logic          right,
  input  logic          left,
  input  logic          sin,
  output logic [BW-1:0] dout,
  output logic          lsb,
  output logic          msb
);
  always_comb begin
    if (right)     dout = {sin, din[BW-1:1]};
    else if (left) dout = {din[BW-2:0], sin};
    else           dout = din;
  end
  assign lsb = din[0];
  assign msb = din[BW-1];
endmodule

// File: rtl/nib_alu_bitsel.sv
module nib_alu_bitsel #(
  parameter int BW = 8,
  localparam int IW = $clog2(BW)
) (
  input  logic [IW-1:0] idx,
  output logic [BW-1:0] mask
);
  for (genvar g = 0; g < BW; g++) begin : g_bit
    assign mask[g] = (idx == IW'(g));
  end

  always_comb begin
    p_mask_onehot_r4: assert ($onehot(mask));
  end
endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         neg,
  input  logic [2:0]   opc,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   full_sum;
  logic [W-1:0] low_sum;
  logic         msb_carry;

  assign b_eff     = (neg || is_sub(opc)) ? ~b : b;
  assign full_sum  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign low_sum   = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, cin};
  assign msb_carry = low_sum[W-1];

  always_comb begin
    cout = 1'b0;
    ovf  = 1'b0;
    case (opc)
      OPC_AND: res = a & b_eff;
      OPC_OR:  res = a | b_eff;
      OPC_XOR: res = a ^ b_eff;
      OPC_PASS: res = a;
      default: begin
        res  = full_sum[W-1:0];
        cout = full_sum[W];
        ovf  = msb_carry ^ full_sum[W];
      end
    endcase
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int NIB_W = 4,
  localparam int BW = 2 * NIB_W,
  localparam int IW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] ext_din,
  input  logic          ext_oe,
  output logic [BW-1:0] ext_dout,
  input  logic [2:0]    bus_src,
  input  logic          sh_right,
  input  logic          sh_left,
  input  logic          sh_in,
  output logic          sh_lsb,
  output logic          sh_msb,
  input  logic [IW-1:0] bit_idx,
  input  logic [1:0]    op1_ld,
  input  logic [1:0]    op2_ld,
  input  logic          op2_neg,
  input  logic          op2_hi,
  input  logic          pass_lo,
  input  logic          pass_hi,
  input  logic [2:0]    op_code,
  input  logic          carry_in,
  input  logic          par_in,
  output logic          par_out,
  output logic          cf,
  output logic          hf,
  output logic          vf,
  output logic          zf,
  output logic          sf,
  output logic          yf,
  output logic          xf,
  output logic          lo_gt9,
  output logic          hi_gt9,
  output logic          hi_eq9
);
  logic [BW-1:0]    op1_q, op2_q, res_q;
  logic [BW-1:0]    ibus, shf_out, bit_mask;
  logic             hf_q, cf_q, vf_q, lo_zero_q, hi_zero_q;
  logic             hi_sel, core_cin, core_cout, core_ovf;
  logic [NIB_W-1:0] a_nib, b_nib, core_res;

  nib_alu_shift #(.BW(BW)) u_shift (
    .din(ext_din), .right(sh_right), .left(sh_left), .sin(sh_in),
    .dout(shf_out), .lsb(sh_lsb), .msb(sh_msb)
  );

  nib_alu_bitsel #(.BW(BW)) u_bitsel (.idx(bit_idx), .mask(bit_mask));

  always_comb begin
    case (bus_src)
      SRC_OP1: ibus = op1_q;
      SRC_OP2: ibus = op2_q;
      SRC_RES: ibus = res_q;
      SRC_SHF: ibus = shf_out;
      SRC_BIT: ibus = bit_mask;
      default: ibus = '0;
    endcase
  end

  assign ext_dout = ext_oe ? ibus : '0;

  // Pass selection: a low pass wins when both pass strobes are high
  assign hi_sel = !pass_lo;
  assign a_nib  = hi_sel ? op1_q[BW-1:NIB_W] : op1_q[NIB_W-1:0];
  assign b_nib  = op2_hi ? op2_q[BW-1:NIB_W] : op2_q[NIB_W-1:0];

  always_comb begin
    case (op_code)
      OPC_ADC: core_cin = carry_in;
      OPC_SUB: core_cin = 1'b1;
      OPC_SBC: core_cin = !carry_in;
      default: core_cin = 1'b0;
    endcase
    if (hi_sel && is_arith(op_code)) core_cin = hf_q;
  end

  nib_alu_core #(.W(NIB_W)) u_core (
    .a(a_nib), .b(b_nib), .neg(op2_neg), .opc(op_code), .cin(core_cin),
    .res(core_res), .cout(core_cout), .ovf(core_ovf)
  );

  assign par_out = par_in ^ (^core_res);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1_q <= '0;
      op2_q <= '0;
    end else begin
      case (op1_ld)
        2'd1: op1_q <= ibus;
        2'd2: op1_q <= {{NIB_W{1'b0}}, ibus[NIB_W-1:0]};
        2'd3: op1_q <= '0;
        default: op1_q <= op1_q;
      endcase
      case (op2_ld)
        2'd1: op2_q <= ibus;
        2'd2: op2_q <= res_q;
        2'd3: op2_q <= '0;
        default: op2_q <= op2_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q     <= '0;
      hf_q      <= 1'b0;
      cf_q      <= 1'b0;
      vf_q      <= 1'b0;
      lo_zero_q <= 1'b1;
      hi_zero_q <= 1'b1;
    end else if (pass_lo) begin
      res_q[NIB_W-1:0] <= core_res;
      hf_q             <= core_cout;
      lo_zero_q        <= (core_res == '0);
    end else if (pass_hi) begin
      res_q[BW-1:NIB_W] <= core_res;
      cf_q              <= core_cout;
      vf_q              <= core_ovf;
      hi_zero_q         <= (core_res == '0);
    end
  end

  assign cf     = cf_q;
  assign hf     = hf_q;
  assign vf     = vf_q;
  assign zf     = lo_zero_q & hi_zero_q;
  assign sf     = res_q[BW-1];
  assign yf     = res_q[BW-3];
  assign xf     = res_q[NIB_W-1];
  assign lo_gt9 = res_q[NIB_W-1:0] > NIB_W'(9);
  assign hi_gt9 = res_q[BW-1:NIB_W] > NIB_W'(9);
  assign hi_eq9 = res_q[BW-1:NIB_W] == NIB_W'(9);

  p_dout_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_oe |-> ext_dout == '0);
  p_low_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_hi && !pass_lo) |=> $stable(res_q[NIB_W-1:0]));
  p_logic_nocarry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_hi && !pass_lo && !is_arith(op_code)) |=> (!cf && !vf));
  p_zero_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    zf == (res_q == '0));
endmodule

// File: tb/nib_alu_tb_top.sv
`timescale 1ns/1ps
module nib_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ext_din;
  logic       ext_oe, sh_right, sh_left, sh_in, op2_neg, op2_hi;
  logic       pass_lo, pass_hi, carry_in, par_in;
  logic [2:0] bus_src, bit_idx, op_code;
  logic [1:0] op1_ld, op2_ld;
  logic [7:0] ext_dout;
  logic sh_lsb, sh_msb, par_out, cf, hf, vf, zf, sf, yf, xf, lo_gt9, hi_gt9, hi_eq9;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int m_op1, m_op2, m_res, m_hf, m_cf, m_vf, m_lz, m_hz;

  always #2 clk = ~clk;

  nib_alu dut_i (.*);

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int shf_model();
    if (sh_right) return (int'(sh_in) << 7) | (int'(ext_din) >> 1);
    if (sh_left)  return ((int'(ext_din) << 1) & 8'hFE) | int'(sh_in);
    return int'(ext_din);
  endfunction

  function automatic int bus_model();
    case (bus_src)
      3'd1: return m_op1;
      3'd2: return m_op2;
      3'd3: return m_res;
      3'd4: return shf_model();
      3'd5: return 1 << bit_idx;
      default: return 0;
    endcase
  endfunction

  // returns ovf*32 + cout*16 + nibble
  function automatic int core_model();
    int a, b, c, s, sa, sb, ss, r, co, ov;
    bit hi;
    hi = !pass_lo;
    a = hi ? (m_op1 >> 4) : (m_op1 & 15);
    b = op2_hi ? (m_op2 >> 4) : (m_op2 & 15);
    if (op2_neg || op_code == 2 || op_code == 3) b = 15 - b;
    co = 0; ov = 0;
    if (op_code <= 3) begin
      if (hi) c = m_hf;
      else if (op_code == 0) c = 0;
      else if (op_code == 1) c = carry_in;
      else if (op_code == 2) c = 1;
      else c = !carry_in;
      s = a + b + c;
      r = s % 16; co = s / 16;
      sa = (a > 7) ? a - 16 : a;
      sb = (b > 7) ? b - 16 : b;
      ss = sa + sb + c;
      ov = (ss > 7 || ss < -8) ? 1 : 0;
    end else if (op_code == 4) r = a & b;
    else if (op_code == 5) r = a | b;
    else if (op_code == 6) r = a ^ b;
    else r = a;
    return ov * 32 + co * 16 + r;
  endfunction

  function automatic int par_model();
    int r, p;
    r = core_model() & 15;
    p = par_in;
    for (int i = 0; i < 4; i++) p ^= (r >> i) & 1;
    return p;
  endfunction

  function automatic int flags_model();
    int lo, hi;
    lo = m_res & 15; hi = m_res >> 4;
    return (m_cf << 9) | (m_hf << 8) | (m_vf << 7) | ((m_lz & m_hz) << 6) |
           (((m_res >> 7) & 1) << 5) | (((m_res >> 5) & 1) << 4) |
           (((m_res >> 3) & 1) << 3) | ((lo > 9) << 2) | ((hi > 9) << 1) | (hi == 9);
  endfunction

  function automatic int flags_dut();
    return {cf, hf, vf, zf, sf, yf, xf, lo_gt9, hi_gt9, hi_eq9};
  endfunction

  task automatic idle();
    ext_din = 8'h00; ext_oe = 1; bus_src = 0; sh_right = 0; sh_left = 0; sh_in = 0;
    bit_idx = 0; op1_ld = 0; op2_ld = 0; op2_neg = 0; op2_hi = 0;
    pass_lo = 0; pass_hi = 0; op_code = 0; carry_in = 0; par_in = 0;
  endtask

  // inputs are set at a falling edge; checks every cycle against the model
  task automatic cyc(string tag);
    int bus, core, nres;
    #1;
    bus = bus_model();
    core = core_model();
    check(tag, ext_dout, ext_oe ? bus : 0);
    check(tag, par_out, par_model());
    check(tag, {sh_msb, sh_lsb}, {ext_din[7], ext_din[0]});
    @(posedge clk);
    nres = m_res;
    if (pass_lo) begin
      nres = (m_res & 8'hF0) | (core & 15);
      m_hf = (core >> 4) & 1; m_lz = ((core & 15) == 0);
    end else if (pass_hi) begin
      nres = (m_res & 8'h0F) | ((core & 15) << 4);
      m_cf = (core >> 4) & 1; m_vf = (core >> 5) & 1; m_hz = ((core & 15) == 0);
    end
    if (op1_ld == 1) m_op1 = bus; else if (op1_ld == 2) m_op1 = bus & 15; else if (op1_ld == 3) m_op1 = 0;
    if (op2_ld == 1) m_op2 = bus; else if (op2_ld == 2) m_op2 = m_res; else if (op2_ld == 3) m_op2 = 0;
    m_res = nres;
    @(negedge clk);
    check(tag, flags_dut(), flags_model());
    idle();
  endtask

  task automatic byte_op(int a, int b, int opc, bit cy, bit neg, string tag);
    int p;
    ext_din = a[7:0]; bus_src = 4; op1_ld = 1; cyc("R5");
    ext_din = b[7:0]; bus_src = 4; op2_ld = 1; cyc("R6");
    pass_lo = 1; op_code = opc[2:0]; carry_in = cy; op2_neg = neg; #1;
    p = par_model(); cyc(tag);
    pass_hi = 1; op2_hi = 1; op_code = opc[2:0]; carry_in = cy; op2_neg = neg; par_in = p[0];
    cyc("R10");
    bus_src = 3; cyc("R7");
  endtask

  initial begin
    idle();
    m_op1 = 0; m_op2 = 0; m_res = 0; m_hf = 0; m_cf = 0; m_vf = 0; m_lz = 1; m_hz = 1;
    repeat (3) @(negedge clk);
    check("R1", flags_dut(), 10'b0001000000);
    rst_n = 1;
    bus_src = 3; cyc("R1");
    bus_src = 1; cyc("R1");
    // R3 shifter
    ext_din = 8'h24; bus_src = 4; sh_right = 1; sh_in = 1; op1_ld = 1; cyc("R3");
    bus_src = 1; #1; check("R3", ext_dout, 8'h92); cyc("R5");
    ext_din = 8'h81; bus_src = 4; sh_left = 1; #1; check("R3", ext_dout, 8'h02); cyc("R3");
    ext_din = 8'h81; bus_src = 4; sh_left = 1; sh_right = 1; sh_in = 0; cyc("R3");
    // R4 mask
    bit_idx = 3; bus_src = 5; op2_ld = 1; cyc("R4");
    bus_src = 2; #1; check("R4", ext_dout, 8'h08); cyc("R6");
    bit_idx = 7; bus_src = 5; cyc("R4");
    // R2 quiet output
    ext_oe = 0; bus_src = 2; #1; check("R2", ext_dout, 0); cyc("R2");
    bus_src = 6; cyc("R2");
    // R7 example
    byte_op(8'h8C, 8'h68, 0, 0, 0, "R7");
    bus_src = 3; #1; check("R7", ext_dout, 8'hF4); check("R9", {cf, hf, vf}, 3'b010); cyc("R7");
    // R5 / R6 load variants
    ext_din = 8'h5A; bus_src = 4; op1_ld = 2; op2_ld = 2; cyc("R5");
    bus_src = 1; #1; check("R5", ext_dout, 8'h0A); op1_ld = 3; cyc("R5");
    bus_src = 2; #1; check("R6", ext_dout, 8'hF4); op2_ld = 3; cyc("R6");
    bus_src = 1; cyc("R5");
    bus_src = 2; cyc("R6");
    // R8 / R9 / R11 / R12 corners
    byte_op(8'h00, 8'h00, 2, 0, 0, "R11");
    byte_op(8'h50, 8'h30, 0, 0, 0, "R9");
    byte_op(8'h99, 8'h00, 0, 0, 0, "R12");
    byte_op(8'hA5, 8'h0F, 4, 0, 0, "R8");
    byte_op(8'h12, 8'h34, 3, 1, 0, "R8");
    for (int i = 0; i < 60; i++)
      byte_op($urandom % 256, $urandom % 256, i % 8, $urandom % 2, (i % 5) == 0, "R8");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog R1 got=hung exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule